// File: doc/BRIEF.md
# Address-Coded Command Packer

This block accepts host writes into a mapped command window and turns each write into a 32-bit command token. The write address, not the data, names the command: an 8-bit opcode is lifted from the address bits just above the word offset. It is placed above the low 24 bits of the write data to form the token. Tokens collect in a staging line of 32 words, which matches one 128-byte cache line. The line goes to the downstream command FIFO as one back-to-back burst. The burst starts on its own when the line fills, or when the host asks for a flush. A flush is needed, for example, before the writing process moves to another CPU.

The host writer does not poll FIFO status. The block compares the FIFO occupancy with a programmable high mark and raises an interrupt. The interrupt then stays up until occupancy drains to a programmable low mark. The writer can therefore sleep on the interrupt. While a burst is in progress, the host port is stalled.

Top module: `cmd_addr_packer`

## Requirements
- R1: A write is a command only when address bits [15:10] equal 6'b101010. Any other write is accepted (ready high) and dropped, and it produces no token.
- R2: Each token is {address[9:2], data[23:0]}: the opcode sits in bits [31:24] and the operand in bits [23:0].
- R3: Tokens leave in the order they were written, one per cycle, with `out_valid` high for every cycle of a burst.
- R4: The write that places the 32nd token starts a burst in the next cycle with no host action. The burst carries all 32 tokens, and `out_last` is high on the 32nd.
- R5: A flush with k>0 tokens pending starts a burst of exactly k tokens in the cycle after the flush, with `out_last` high on the k-th.
- R6: A flush with no tokens pending produces no output.
- R7: `host_ready` is low for every cycle in which a burst is being sent and high in all other cycles.
- R8: In the cycle after an edge at which `fifo_level >= hi_mark`, `irq` is high.
- R9: Once set, `irq` stays high until an edge at which `fifo_level <= lo_mark`, and it is low in the cycle after that edge.
- R10: After reset, `irq` and `out_valid` are low, `host_ready` is high and no tokens are pending.
- R11: A command write and a flush in the same cycle put that write's token in the flushed burst as its final token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host write request |
| host_addr | input | 16 | Host write byte address |
| host_data | input | 32 | Host write data |
| host_ready | output | 1 | Write accepted when high |
| flush_req | input | 1 | Push out the partial line |
| fifo_level | input | 10 | Downstream FIFO occupancy |
| hi_mark | input | 10 | Near-full threshold |
| lo_mark | input | 10 | Drain threshold |
| out_valid | output | 1 | Token word valid |
| out_data | output | 32 | Token word |
| out_last | output | 1 | Final word of a burst |
| irq | output | 1 | Near-full interrupt |

## Verification
The assertions assume that the downstream FIFO takes every burst word without stalling. They also assume that `lo_mark` is below `hi_mark`, and that host writes are offered only as the block's own ready allows. The bench keeps the marks ordered, with a gap between them. It only starts a write when ready is high, and it drains each burst to its last word before the next write. It never drives a stall on the output, because the output has no stall input. Within those limits, the random mix covers window hits and misses, opcodes and flush points at random. Directed cases cover the full line, the empty flush, a write combined with a flush, and the exact threshold crossings.

// File: rtl/cap_pkg.sv
// Shared definitions for the address-coded command packer.
// Assumes a 32-bit token with an 8-bit opcode above a 24-bit operand.
package cap_pkg;
    localparam int WORD_W = 32;
    localparam int OP_W   = 8;
    localparam int OP_LSB = 2;
    localparam int ARG_W  = WORD_W - OP_W;

    typedef enum logic {ST_FILL, ST_DRAIN} stage_st_e;

    // Build a token from opcode and operand bits.
    function automatic logic [WORD_W-1:0] make_token(
        input logic [OP_W-1:0]  op,
        input logic [ARG_W-1:0] arg
    );
        return {op, arg};
    endfunction
endpackage

// File: rtl/cap_decode.sv
// Window decoder: flags writes inside the command window and builds the token.
// Assumes byte addresses, with the opcode directly above the 2-bit word offset.
module cap_decode
    import cap_pkg::*;
#(
    parameter int AW        = 16,
    parameter int WIN_LSB   = OP_LSB + OP_W,
    parameter logic [AW-WIN_LSB-1:0] WIN_BASE = '1
) (
    input  logic              wr_fire,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] data,
    output logic              tok_we,
    output logic [WORD_W-1:0] tok
);
    logic unused_bits;

    // Window hit and token packing.
    always_comb begin
        tok_we      = wr_fire && (addr[AW-1:WIN_LSB] == WIN_BASE);
        tok         = make_token(addr[OP_LSB +: OP_W], data[ARG_W-1:0]);
        unused_bits = ^{addr[OP_LSB-1:0], data[WORD_W-1:ARG_W]};
    end
endmodule

// File: rtl/cap_stage.sv
// Staging line: collects tokens and sends the line as one burst when it is
// full or when a flush arrives. Assumes the downstream side never stalls.
module cap_stage
    import cap_pkg::*;
#(
    parameter int LINE_WORDS = 32,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int CNT_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_we,
    input  logic [WORD_W-1:0] tok,
    input  logic              flush_req,
    output logic              filling,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    stage_st_e         st;
    logic [WORD_W-1:0] line_mem [LINE_WORDS];
    logic [CNT_W-1:0]  fill_cnt;
    logic [CNT_W-1:0]  fill_next;
    logic [CNT_W-1:0]  burst_len;
    logic [IDX_W-1:0]  rd_idx;
    logic              store;
    logic              go_burst;

    // Next fill count and the burst trigger.
    always_comb begin
        store     = tok_we && (st == ST_FILL);
        fill_next = fill_cnt + CNT_W'(store);
        go_burst  = (st == ST_FILL) &&
                    ((fill_next == CNT_W'(LINE_WORDS)) ||
                     (flush_req && (fill_next != '0)));
    end

    // Token storage; needs no reset because it is written before it is read.
    always_ff @(posedge clk) begin
        if (store) line_mem[fill_cnt[IDX_W-1:0]] <= tok;
    end

    // Fill and drain sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_FILL;
            fill_cnt  <= '0;
            burst_len <= '0;
            rd_idx    <= '0;
        end else begin
            case (st)
                ST_FILL: begin
                    if (go_burst) begin
                        st        <= ST_DRAIN;
                        burst_len <= fill_next;
                        rd_idx    <= '0;
                        fill_cnt  <= '0;
                    end else begin
                        fill_cnt  <= fill_next;
                    end
                end
                default: begin
                    rd_idx <= rd_idx + 1'b1;
                    if (out_last) st <= ST_FILL;
                end
            endcase
        end
    end

    // Output word selection.
    always_comb begin
        filling   = (st == ST_FILL);
        out_valid = (st == ST_DRAIN);
        out_data  = line_mem[rd_idx];
        out_last  = out_valid && (CNT_W'(rd_idx) == burst_len - 1'b1);
    end
endmodule

// File: rtl/cap_mark.sv
// Watermark interrupt: sets at the high mark, holds until the low mark.
// Assumes lo_th is below hi_th.
module cap_mark #(
    parameter int OCC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] level,
    input  logic [OCC_W-1:0] hi_th,
    input  logic [OCC_W-1:0] lo_th,
    output logic             irq
);
    // Set/clear with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq <= 1'b0;
        else if (!irq && level >= hi_th) irq <= 1'b1;
        else if (irq && level <= lo_th)  irq <= 1'b0;
    end
endmodule

// File: rtl/cmd_addr_packer.sv
// Top: host command window to line-burst token stream, with watermark interrupt.
// Assumes the downstream FIFO accepts every burst word.
module cmd_addr_packer
    import cap_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LINE_WORDS = 32,
    parameter int OCC_W      = 10,
    localparam int WIN_LSB   = OP_LSB + OP_W,
    parameter logic [AW-WIN_LSB-1:0] WIN_BASE = 6'b101010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_data,
    output logic              host_ready,
    input  logic              flush_req,
    input  logic [OCC_W-1:0]  fifo_level,
    input  logic [OCC_W-1:0]  hi_mark,
    input  logic [OCC_W-1:0]  lo_mark,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic              irq
);
    logic              tok_we;
    logic [WORD_W-1:0] tok;
    logic              filling;

    // The host port is open only while the line fills.
    always_comb host_ready = filling;

    cap_decode #(.AW(AW), .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE)) u_dec (
        .wr_fire (host_valid && host_ready),
        .addr    (host_addr),
        .data    (host_data),
        .tok_we  (tok_we),
        .tok     (tok)
    );

    cap_stage #(.LINE_WORDS(LINE_WORDS)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_we    (tok_we),
        .tok       (tok),
        .flush_req (flush_req),
        .filling   (filling),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    cap_mark #(.OCC_W(OCC_W)) u_mark (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fifo_level),
        .hi_th (hi_mark),
        .lo_th (lo_mark),
        .irq   (irq)
    );
endmodule

// File: rtl/cap_chk.sv
// Property checker for the packer, attached with bind.
module cap_chk #(
    parameter int LINE_WORDS = 32,
    parameter int OCC_W      = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tok_we,
    input logic             host_ready,
    input logic             out_valid,
    input logic             out_last,
    input logic             irq,
    input logic [OCC_W-1:0] fifo_level,
    input logic [OCC_W-1:0] hi_mark,
    input logic [OCC_W-1:0] lo_mark
);
    int pend;

    // Count accepted tokens not yet sent.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 0;
        else        pend <= pend + int'(tok_we) - int'(out_valid);
    end

    // R7
    ready_low_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !host_ready);
    // R3
    burst_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);
    // R4
    line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= LINE_WORDS);
    // R5
    burst_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> (pend == 0 && !out_valid));
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fifo_level >= hi_mark));
    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(fifo_level <= lo_mark));
endmodule

bind cmd_addr_packer cap_chk #(.LINE_WORDS(LINE_WORDS), .OCC_W(OCC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_we     (tok_we),
    .host_ready (host_ready),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .irq        (irq),
    .fifo_level (fifo_level),
    .hi_mark    (hi_mark),
    .lo_mark    (lo_mark)
);

// File: tb/cmd_addr_packer_test.sv
module cmd_addr_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_data = '0;
    logic        host_ready;
    logic        flush_req = 1'b0;
    logic [9:0]  fifo_level = '0;
    logic [9:0]  hi_mark = 10'd600;
    logic [9:0]  lo_mark = 10'd200;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q [32];
    int exp_n = 0;
    int seed_v;

    always #2.5 clk = ~clk;

    cmd_addr_packer uut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
        .host_data(host_data), .host_ready(host_ready), .flush_req(flush_req),
        .fifo_level(fifo_level), .hi_mark(hi_mark), .lo_mark(lo_mark),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected token from the R1/R2 rules; returns 0 in hit when outside the window.
    function automatic logic [31:0] tok_of(input logic [15:0] a, input logic [31:0] d,
                                           output bit hit);
        hit = (a[15:10] == 6'b101010);
        return {a[9:2], d[23:0]};
    endfunction

    // Check a burst of n words starting now (R3, R4, R5, R7).
    task automatic collect(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(out_valid == 1'b1, req, 32'(out_valid), 32'd1);
            chk(out_data == exp_q[i], "R3", out_data, exp_q[i]);
            chk(out_last == (i == n - 1), req, 32'(out_last), 32'(i == n - 1));
            chk(host_ready == 1'b0, "R7", 32'(host_ready), 32'd0);
            @(negedge clk);
        end
        chk(out_valid == 1'b0, req, 32'(out_valid), 32'd0);
        chk(host_ready == 1'b1, "R7", 32'(host_ready), 32'd1);
        exp_n = 0;
    endtask

    // One host write, optionally with a flush in the same cycle.
    task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit fl);
        bit hit;
        logic [31:0] t;
        t = tok_of(a, d, hit);
        host_valid = 1'b1; host_addr = a; host_data = d; flush_req = fl;
        @(negedge clk);
        host_valid = 1'b0; flush_req = 1'b0;
        if (hit) begin
            exp_q[exp_n] = t;
            exp_n++;
        end
        if (exp_n == 32)         collect(32, "R4");
        else if (fl && exp_n > 0) collect(exp_n, "R11");
        else if (!hit)            chk(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
    endtask

    task automatic flush();
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        if (exp_n > 0) collect(exp_n, "R5");
        else begin
            for (int i = 0; i < 3; i++) begin
                chk(out_valid == 1'b0, "R6", 32'(out_valid), 32'd0);
                @(negedge clk);
            end
        end
    endtask

    function automatic logic [15:0] hit_addr(input logic [7:0] op);
        return {6'b101010, op, 2'b00};
    endfunction

    // Expected interrupt state after an edge (R8, R9).
    function automatic bit irq_next(input bit cur, input int lvl, input int hi, input int lo);
        if (!cur && lvl >= hi) return 1'b1;
        if (cur && lvl <= lo)  return 1'b0;
        return cur;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ei;
        int lvl;
        seed_v = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
        chk(irq == 1'b0, "R10", 32'(irq), 32'd0);
        chk(host_ready == 1'b1, "R10", 32'(host_ready), 32'd1);
        flush(); // R6 and R10: nothing pending after reset

        // R2 directed token, R5 single-word flush
        wr(hit_addr(8'hC3), 32'hFFAB_CDEF, 1'b0);
        chk(exp_q[0] == 32'hC3AB_CDEF, "R2", exp_q[0], 32'hC3AB_CDEF);
        flush();
        // R1 miss alone then empty flush
        wr(16'h1234, 32'h1, 1'b0);
        flush();
        // R4 full line
        for (int i = 0; i < 32; i++) wr(hit_addr(8'(i)), 32'(i * 7 + 1), 1'b0);
        // R11 write with flush
        wr(hit_addr(8'h11), 32'h0000_0AAA, 1'b0);
        wr(hit_addr(8'h22), 32'h0000_0BBB, 1'b1);
        // R11 write with flush on empty buffer
        wr(hit_addr(8'h33), 32'h0000_0CCC, 1'b1);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [15:0] a;
            logic [5:0] hb;
            int r;
            r = int'($urandom_range(0, 99));
            a = 16'($urandom());
            if (r < 75) a[15:10] = 6'b101010;
            else begin
                hb = 6'($urandom());
                if (hb == 6'b101010) hb = 6'b000001;
                a[15:10] = hb;
            end
            if (r < 8) flush();
            else wr(a, $urandom(), (r % 17) == 0);
        end
        flush();

        // Interrupt thresholds
        hi_mark = 10'd500; lo_mark = 10'd300; ei = 1'b0;
        fifo_level = 10'd499; @(negedge clk);
        chk(irq == 1'b0, "R8", 32'(irq), 32'd0);
        fifo_level = 10'd500; @(negedge clk); ei = 1'b1;
        chk(irq == 1'b1, "R8", 32'(irq), 32'd1);
        fifo_level = 10'd301; @(negedge clk);
        chk(irq == 1'b1, "R9", 32'(irq), 32'd1);
        fifo_level = 10'd300; @(negedge clk); ei = 1'b0;
        chk(irq == 1'b0, "R9", 32'(irq), 32'd0);
        lvl = 400;
        for (int it = 0; it < 600; it++) begin
            lvl = lvl + int'($urandom_range(0, 120)) - 60;
            if (lvl < 0) lvl = 0;
            if (lvl > 1023) lvl = 1023;
            fifo_level = 10'(lvl);
            @(negedge clk);
            ei = irq_next(ei, lvl, 500, 300);
            chk(irq == ei, ei ? "R8" : "R9", 32'(irq), 32'(ei));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule